// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

An integer multiply-accumulate unit that keeps a 64-bit running total in two 32-bit registers, a high half and a low half, which together form one signed value with the high half on top. On a start strobe it forms a signed product of the two operands, adds it to the total and writes the sum back on the same clock edge. A done pulse follows in the next cycle.

Two product widths are offered. The long form multiplies the full 32-bit operands as signed values. The word form multiplies only the signed low 16 bits of each operand. A saturation-mode input changes how the sum is written back, and each product width has its own rule. The long form forces the top bits of the high half to a sign pattern. The word form clamps the sum to the signed 32-bit range and marks a clamp by setting the high half to one.

Each half also has its own write port, which loads a value and clears the half when that value is zero. Software-visible access, operand fetch and decode belong to the surrounding core.

Top module: `sat_mac`

## Requirements
- R1: After reset both accumulator halves read zero and `done_o` is low.
- R2: With `op_word_i`=0 (long form) and `sat_en_i`=0, a start sign-extends both 32-bit operands and adds their 64-bit product to {hi,lo}, wrapping modulo 2^64.
- R3: With `op_word_i`=1 (word form) and `sat_en_i`=0, a start adds the signed product of operand bits [15:0] to {hi,lo}, wrapping modulo 2^64. Operand bits [31:16] have no effect.
- R4: In the long form with `sat_en_i`=1, a negative 64-bit sum (bit 63 set) is stored with hi bits [31:16] forced to ones.
- R5: In the long form with `sat_en_i`=1, a non-negative sum is stored with hi bits [31:15] cleared, while hi bits [14:0] and all of lo keep the sum.
- R6: In the word form with `sat_en_i`=1, a sum below -2^31 stores hi=0x00000001 and lo=0x80000000.
- R7: In the word form with `sat_en_i`=1, a sum above 2^31-1 stores hi=0x00000001 and lo=0x7FFFFFFF.
- R8: In the word form with `sat_en_i`=1, a sum within [-2^31, 2^31-1] is stored unchanged as the full 64-bit value. This includes both end points.
- R9: The result appears on the outputs after the clock edge that samples `start_i`. `done_o` is high for exactly the following cycle. Without a start or a write, both halves hold their value.
- R10: `hi_we_i` loads `hi_wdata_i` into the high half and `lo_we_i` loads `lo_wdata_i` into the low half, so loading zero clears that half. If a write and a start fall in the same cycle, the written half takes the write data and the other half takes the operation result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start one multiply-accumulate |
| op_word_i | input | 1 | 0: long form, 1: word form |
| sat_en_i | input | 1 | Saturation mode |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand |
| hi_we_i | input | 1 | Write enable, high half |
| hi_wdata_i | input | 32 | Write data, high half |
| lo_we_i | input | 1 | Write enable, low half |
| lo_wdata_i | input | 32 | Write data, low half |
| acc_hi_o | output | 32 | Accumulator high half |
| acc_lo_o | output | 32 | Accumulator low half |
| done_o | output | 1 | One-cycle pulse after a start |

## Verification
The saturation-range assertions only judge an operation that has no write to either half in the same cycle, because a write there may legally place any value in the accumulator. The bench keeps its preloads and its operations in separate cycles. It sets up both halves before a start, and combines a write with a start only in the directed priority tests. The hold assertion assumes that no start arrives when no result is wanted, so the bench drops `start_i` in the cycle after each operation and checks that the value holds.

// File: rtl/sat_mac_pkg.sv
package sat_mac_pkg;
  typedef enum logic {
    OP_LONG = 1'b0,
    OP_WORD = 1'b1
  } mac_op_e;
endpackage

// File: rtl/sat_mac_mult.sv
module sat_mac_mult
  import sat_mac_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SHORT_W = 16,
  localparam int ACC_W = 2 * DATA_W
) (
  input  mac_op_e            op_i,
  input  logic [DATA_W-1:0]  a_i,
  input  logic [DATA_W-1:0]  b_i,
  output logic [ACC_W-1:0]   prod_o
);
  localparam int SP_W = 2 * SHORT_W;

  logic signed [ACC_W-1:0] long_p;
  logic signed [SP_W-1:0]  short_p;

  assign long_p  = ACC_W'($signed(a_i)) * ACC_W'($signed(b_i));
  assign short_p = $signed(a_i[SHORT_W-1:0]) * $signed(b_i[SHORT_W-1:0]);

  always_comb begin
    if (op_i == OP_WORD) prod_o = {{(ACC_W-SP_W){short_p[SP_W-1]}}, short_p};
    else                 prod_o = long_p;
  end
endmodule

// File: rtl/sat_mac_sat.sv
module sat_mac_sat
  import sat_mac_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int ACC_W = 2 * DATA_W
) (
  input  mac_op_e            op_i,
  input  logic               sat_en_i,
  input  logic [ACC_W-1:0]   sum_i,
  output logic [DATA_W-1:0]  hi_o,
  output logic [DATA_W-1:0]  lo_o
);
  localparam int FILL_W = DATA_W / 2;
  localparam int KEEP_W = DATA_W / 2 - 1;
  localparam logic [DATA_W-1:0] FILL_MASK = {{FILL_W{1'b1}}, {(DATA_W-FILL_W){1'b0}}};
  localparam logic [DATA_W-1:0] KEEP_MASK = {{(DATA_W-KEEP_W){1'b0}}, {KEEP_W{1'b1}}};
  localparam logic [DATA_W-1:0] CLAMP_HI  = DATA_W'(1);
  localparam logic [DATA_W-1:0] LO_MIN    = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] LO_MAX    = {1'b0, {(DATA_W-1){1'b1}}};

  logic [DATA_W-1:0] sum_hi, sum_lo;
  logic [ACC_W-DATA_W:0] ext_bits;
  logic neg, fits;

  assign sum_hi   = sum_i[ACC_W-1:DATA_W];
  assign sum_lo   = sum_i[DATA_W-1:0];
  assign neg      = sum_i[ACC_W-1];
  // sum fits the signed 32-bit range when bits [63:31] are all equal
  assign ext_bits = sum_i[ACC_W-1:DATA_W-1];
  assign fits     = (&ext_bits) | ~(|ext_bits);

  always_comb begin
    hi_o = sum_hi;
    lo_o = sum_lo;
    if (sat_en_i) begin
      if (op_i == OP_LONG) begin
        hi_o = neg ? (sum_hi | FILL_MASK) : (sum_hi & KEEP_MASK);
      end else if (!fits) begin
        hi_o = CLAMP_HI;
        lo_o = neg ? LO_MIN : LO_MAX;
      end
    end
  end
endmodule

// File: rtl/sat_mac.sv
module sat_mac
  import sat_mac_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SHORT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              op_word_i,
  input  logic              sat_en_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic              hi_we_i,
  input  logic [DATA_W-1:0] hi_wdata_i,
  input  logic              lo_we_i,
  input  logic [DATA_W-1:0] lo_wdata_i,
  output logic [DATA_W-1:0] acc_hi_o,
  output logic [DATA_W-1:0] acc_lo_o,
  output logic              done_o
);
  localparam int ACC_W  = 2 * DATA_W;
  localparam int KEEP_W = DATA_W / 2 - 1;

  mac_op_e            op;
  logic [ACC_W-1:0]   prod, sum;
  logic [DATA_W-1:0]  res_hi, res_lo;

  assign op  = mac_op_e'(op_word_i);
  assign sum = {acc_hi_o, acc_lo_o} + prod;

  sat_mac_mult #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) u_mult (
    .op_i   (op),
    .a_i    (opa_i),
    .b_i    (opb_i),
    .prod_o (prod)
  );

  sat_mac_sat #(.DATA_W(DATA_W)) u_sat (
    .op_i     (op),
    .sat_en_i (sat_en_i),
    .sum_i    (sum),
    .hi_o     (res_hi),
    .lo_o     (res_lo)
  );

  // write ports override the op result per half
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_hi_o <= '0;
      acc_lo_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= start_i;
      if (hi_we_i)      acc_hi_o <= hi_wdata_i;
      else if (start_i) acc_hi_o <= res_hi;
      if (lo_we_i)      acc_lo_o <= lo_wdata_i;
      else if (start_i) acc_lo_o <= res_lo;
    end
  end

  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o);

  a_r9_hold_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !hi_we_i) |=> $stable(acc_hi_o));

  a_r10_hi_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_we_i |=> (acc_hi_o == $past(hi_wdata_i)));

  a_r10_lo_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_we_i |=> (acc_lo_o == $past(lo_wdata_i)));

  // R4/R5: long-form saturation leaves a sign pattern in the high half
  a_r5_long_sat_form: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && sat_en_i && !op_word_i && !hi_we_i && !lo_we_i) |=>
      ((acc_hi_o[DATA_W-1:KEEP_W] == '0) || (&acc_hi_o[DATA_W-1:KEEP_W+1])));

  // R6/R7/R8: word-form saturation yields an in-range value or a marked clamp
  a_r8_word_sat_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && sat_en_i && op_word_i && !hi_we_i && !lo_we_i) |=>
      ((&{acc_hi_o, acc_lo_o[DATA_W-1]}) || !(|{acc_hi_o, acc_lo_o[DATA_W-1]}) ||
       ((acc_hi_o == DATA_W'(1)) &&
        ((acc_lo_o == {1'b1, {(DATA_W-1){1'b0}}}) ||
         (acc_lo_o == {1'b0, {(DATA_W-1){1'b1}}})))));
endmodule

// File: tb/sat_mac_test.sv
module sat_mac_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        word;
    logic        sat;
    logic [31:0] phi;
    logic [31:0] plo;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] ehi;
    logic [31:0] elo;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 32'h0,        32'h0,        32'h3,        32'h5,        32'h0,        32'hF,        8'd2}, // R2
    '{1'b0, 1'b0, 32'h0,        32'h0,        32'hFFFFFFFE, 32'h3,        32'hFFFFFFFF, 32'hFFFFFFFA, 8'd2}, // R2 negative
    '{1'b0, 1'b0, 32'h0,        32'hFFFFFFFF, 32'h1,        32'h1,        32'h1,        32'h0,        8'd2}, // R2 carry
    '{1'b0, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h1,        32'h1,        32'h0,        32'h0,        8'd2}, // R2 wrap
    '{1'b0, 1'b0, 32'h0,        32'h0,        32'h80000000, 32'h80000000, 32'h40000000, 32'h0,        8'd2}, // R2 min*min
    '{1'b1, 1'b0, 32'h0,        32'h0,        32'hABCD0003, 32'h1234FFFE, 32'hFFFFFFFF, 32'hFFFFFFFA, 8'd3}, // R3 upper bits ignored
    '{1'b1, 1'b0, 32'h0,        32'h0,        32'h00008000, 32'h00008000, 32'h0,        32'h40000000, 8'd3}, // R3
    '{1'b0, 1'b1, 32'h80000000, 32'h0,        32'h0,        32'h0,        32'hFFFF0000, 32'h0,        8'd4}, // R4
    '{1'b0, 1'b1, 32'h12345678, 32'h5,        32'h2,        32'h3,        32'h00005678, 32'hB,        8'd5}, // R5
    '{1'b0, 1'b1, 32'h0000FFFF, 32'h0,        32'h0,        32'h0,        32'h00007FFF, 32'h0,        8'd5}, // R5 bit 15
    '{1'b1, 1'b1, 32'hFFFFFFFF, 32'h80000000, 32'h1,        32'h0000FFFF, 32'h1,        32'h80000000, 8'd6}, // R6
    '{1'b1, 1'b1, 32'h0,        32'h7FFFFFFF, 32'h1,        32'h1,        32'h1,        32'h7FFFFFFF, 8'd7}, // R7
    '{1'b1, 1'b1, 32'hFFFFFFFF, 32'hFFFFFFF0, 32'h4,        32'h2,        32'hFFFFFFFF, 32'hFFFFFFF8, 8'd8}, // R8
    '{1'b1, 1'b1, 32'h0,        32'h7FFFFFFE, 32'h1,        32'h1,        32'h0,        32'h7FFFFFFF, 8'd8}, // R8 top edge
    '{1'b1, 1'b1, 32'hFFFFFFFF, 32'h80000001, 32'h1,        32'h0000FFFF, 32'hFFFFFFFF, 32'h80000000, 8'd8}  // R8 bottom edge
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, op_word = 1'b0, sat_en = 1'b0;
  logic [31:0] opa = '0, opb = '0;
  logic        hi_we = 1'b0, lo_we = 1'b0;
  logic [31:0] hi_wd = '0, lo_wd = '0;
  logic [31:0] acc_hi, acc_lo;
  logic        done;
  int          total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sat_mac uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_word_i(op_word),
    .sat_en_i(sat_en), .opa_i(opa), .opb_i(opb),
    .hi_we_i(hi_we), .hi_wdata_i(hi_wd), .lo_we_i(lo_we), .lo_wdata_i(lo_wd),
    .acc_hi_o(acc_hi), .acc_lo_o(acc_lo), .done_o(done)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic preload(input logic [31:0] h, input logic [31:0] l);
    @(negedge clk);
    hi_we = 1'b1; hi_wd = h; lo_we = 1'b1; lo_wd = l;
    @(negedge clk);
    hi_we = 1'b0; lo_we = 1'b0;
  endtask

  // drive a start for one cycle; returns at the negedge after the sampling edge
  task automatic run_op(input logic w, input logic s, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    start = 1'b1; op_word = w; sat_en = s; opa = a; opb = b;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 reset state
    #(CLK_PERIOD*2);
    check("R1", {acc_hi, acc_lo}, 64'h0);
    check("R1 done", {63'h0, done}, 64'h0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      preload(VECS[i].phi, VECS[i].plo);
      run_op(VECS[i].word, VECS[i].sat, VECS[i].a, VECS[i].b);
      total++;
      if ({acc_hi, acc_lo} !== {VECS[i].ehi, VECS[i].elo}) begin
        bad++;
        $display("FAIL R%0d vec %0d actual=%h expected=%h", VECS[i].req, i,
                 {acc_hi, acc_lo}, {VECS[i].ehi, VECS[i].elo});
      end
    end

    // R9 done pulse and hold
    preload(32'h0, 32'h10);
    run_op(1'b0, 1'b0, 32'h2, 32'h4);
    check("R9 done high", {63'h0, done}, 64'h1);
    check("R9 result", {acc_hi, acc_lo}, 64'h18);
    @(negedge clk);
    check("R9 done low", {63'h0, done}, 64'h0);
    check("R9 hold", {acc_hi, acc_lo}, 64'h18);
    // R9 back-to-back accumulation
    run_op(1'b1, 1'b0, 32'h3, 32'h3);
    run_op(1'b1, 1'b0, 32'h3, 32'h3);
    check("R9 accumulate", {acc_hi, acc_lo}, 64'h2A);

    // R10 clear via writes
    @(negedge clk); hi_we = 1'b1; hi_wd = 32'h0;
    @(negedge clk); hi_we = 1'b0; lo_we = 1'b1; lo_wd = 32'h0;
    @(negedge clk); lo_we = 1'b0;
    check("R10 clear", {acc_hi, acc_lo}, 64'h0);

    // R10 high write wins over op on same cycle; low takes result
    @(negedge clk);
    start = 1'b1; op_word = 1'b0; sat_en = 1'b0; opa = 32'h1; opb = 32'h7;
    hi_we = 1'b1; hi_wd = 32'hAAAA0000;
    @(negedge clk);
    start = 1'b0; hi_we = 1'b0;
    check("R10 hi priority", {acc_hi, acc_lo}, {32'hAAAA0000, 32'h7});

    // R10 low write wins; high takes carry from op
    preload(32'h0, 32'hFFFFFFFF);
    @(negedge clk);
    start = 1'b1; op_word = 1'b0; opa = 32'h1; opb = 32'h1;
    lo_we = 1'b1; lo_wd = 32'h55;
    @(negedge clk);
    start = 1'b0; lo_we = 1'b0;
    check("R10 lo priority", {acc_hi, acc_lo}, {32'h1, 32'h55});

    // R1 reset mid-run clears state
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 re-reset", {acc_hi, acc_lo}, 64'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule